// File: doc/BRIEF.md
# Masked-Compare CAM Command Engine

This block keeps a small table of 64-bit entries and runs host commands against it through a 16-bit register interface. The host fills four 16-bit key words, then writes a command code. The engine scans the table one entry per clock and pads the scan to a fixed latency. It then updates the table, the key words, a result flag and sticky completion status bits. A 64-bit global mask chooses which key bits take part in a compare. A mask bit of 1 leaves that bit out of the compare.

There are four commands. Set-mask copies the key words into the mask. Insert stores the key in a free slot. Check looks up the key and, on a hit, returns the stored entry. Delete removes the entry that matches the key. A busy output stays high while a command runs. At most one entry may match a given masked key. If duplicates are stored, the results of check and delete are undefined.

Top module: `cam_cmd_engine`

## Requirements
- R1: The 64-bit key is word 3 in bits 63:48, word 2 in 47:32, word 1 in 31:16 and word 0 in 15:0. Word n is written and read at address n.
- R2: An entry matches when it is valid and equals the key on every bit where the global mask holds 0. Bits where the mask holds 1 are not compared.
- R3: Command code 0 (set-mask) loads the concatenated key words into the global mask. The mask changes at no other time.
- R4: Command code 2 (check) behaves as follows.
  - On a hit, it sets the result flag (bit 0 of the flag register at read address 4) and replaces key words 0 to 3 with the whole stored entry, in the R1 order.
  - On a miss, it clears the flag and leaves the key words unchanged.
- R5: A command is accepted by a write to address 4 while idle. From the edge that accepts it, busy_o is high for exactly LATENCY clock cycles. The command's effects appear on the edge where busy_o falls. Bit 1 of the flag register mirrors busy_o.
- R6: While busy_o is high, the block ignores writes to addresses 0 to 4. They start no command and change no key word.
- R7: Command code 3 (delete) behaves as follows.
  - If a matching entry exists, it invalidates that entry and sets the result flag.
  - Otherwise it changes no entry and clears the flag.
- R8: Command code 1 (insert) behaves as follows.
  - If a slot is free, it stores the full key there as a valid entry and sets the result flag.
  - When all DEPTH slots are valid, it stores nothing and clears the flag.
- R9: Completion of the command with code c sets status bit c (read address 6). The bit stays set until the host writes 1 to it at address 6. irq_o is high while any status bit is set whose enable bit is also set (enables at address 5, same bit positions). Status and enable writes are taken even while busy.
- R10: After reset the following all read 0: the key words, the flags, the enables and the status bits. busy_o and irq_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address: 0-3 key words, 4 command, 5 enables, 6 status clear |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 3 | Read address: 0-3 key words, 4 flags, 5 enables, 6 status |
| rd_data_o | output | 16 | Read data, combinational from rd_addr_i |
| busy_o | output | 1 | High while a command runs |
| irq_o | output | 1 | OR of enabled status bits |

## Verification
The bench builds the engine with DEPTH=8 and LATENCY=16. These values let a handful of inserts fill the table, so the full-table refusal of R8 can be reached cheaply. Because LATENCY is larger than DEPTH, the padding cycles after the scan are exercised, and the latency check shows that every command ends on the sixteenth cycle whatever its result. A mask that keeps only the top key word is used to show both the word order and the meaning of a masked bit.

// File: rtl/cam_pkg.sv
package cam_pkg;
  typedef enum logic [1:0] {
    CMD_MASK = 2'd0,
    CMD_INS  = 2'd1,
    CMD_CHK  = 2'd2,
    CMD_DEL  = 2'd3
  } cmd_e;

  localparam int WORD_W  = 16;
  localparam int NWORDS  = 4;
  localparam int KEY_W   = WORD_W * NWORDS;
  localparam int NSTS    = 4;

  localparam logic [2:0] A_CMD = 3'd4;
  localparam logic [2:0] A_FLG = 3'd4;
  localparam logic [2:0] A_IEN = 3'd5;
  localparam logic [2:0] A_STS = 3'd6;
endpackage

// File: rtl/cam_store.sv
module cam_store
  import cam_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [KEY_W-1:0] key_i,
  input  logic [KEY_W-1:0] mask_i,
  input  logic [IW-1:0]    cmp_idx_i,
  output logic             cmp_hit_o,
  output logic             cmp_free_o,
  input  logic [IW-1:0]    res_idx_i,
  output logic [KEY_W-1:0] res_ent_o,
  input  logic             ins_i,
  input  logic             del_i
);
  logic [DEPTH-1:0][KEY_W-1:0] ent_q;
  logic [DEPTH-1:0]            vld_q;
  logic [DEPTH-1:0]            row_hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    assign row_hit[g] = vld_q[g] & ~|((ent_q[g] ^ key_i) & ~mask_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q[g] <= '0;
        vld_q[g] <= 1'b0;
      end else if (res_idx_i == IW'(g)) begin
        if (ins_i) begin
          ent_q[g] <= key_i;
          vld_q[g] <= 1'b1;
        end else if (del_i) begin
          vld_q[g] <= 1'b0;
        end
      end
    end
  end

  assign cmp_hit_o  = row_hit[cmp_idx_i];
  assign cmp_free_o = ~vld_q[cmp_idx_i];
  assign res_ent_o  = ent_q[res_idx_i];

  a_r7_table_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ins_i || del_i) |=> $stable(vld_q));
  a_r7_del_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    del_i && !ins_i |=> !vld_q[$past(res_idx_i)]);
  a_r8_ins_stores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_i |=> vld_q[$past(res_idx_i)] && ent_q[$past(res_idx_i)] == $past(key_i));
endmodule

// File: rtl/cam_seq.sv
module cam_seq
  import cam_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int LATENCY = 16,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(LATENCY)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  cmd_e          cmd_i,
  input  logic          cmp_hit_i,
  input  logic          cmp_free_i,
  output logic [IW-1:0] cmp_idx_o,
  output logic          busy_o,
  output logic          done_o,
  output cmd_e          cmd_o,
  output logic          fin_found_o,
  output logic [IW-1:0] fin_idx_o
);
  logic [CW-1:0] cnt_q;
  logic          busy_q, found_q;
  logic [IW-1:0] idx_q;
  cmd_e          cmd_q;
  logic          in_range, last, cond, step_hit;

  assign cmp_idx_o = cnt_q[IW-1:0];
  assign in_range  = int'(cnt_q) < DEPTH;
  assign last      = int'(cnt_q) == LATENCY - 1;

  always_comb begin
    unique case (cmd_q)
      CMD_INS:          cond = cmp_free_i;
      CMD_CHK, CMD_DEL: cond = cmp_hit_i;
      default:          cond = 1'b0;
    endcase
  end

  // first qualifying slot in index order wins
  assign step_hit    = busy_q & in_range & cond & ~found_q;
  assign done_o      = busy_q & last;
  assign fin_found_o = found_q | step_hit;
  assign fin_idx_o   = found_q ? idx_q : cnt_q[IW-1:0];
  assign busy_o      = busy_q;
  assign cmd_o       = cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      found_q <= 1'b0;
      idx_q   <= '0;
      cmd_q   <= CMD_MASK;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q  <= 1'b1;
        cnt_q   <= '0;
        found_q <= 1'b0;
        cmd_q   <= cmd_i;
      end
    end else begin
      if (step_hit) begin
        found_q <= 1'b1;
        idx_q   <= cnt_q[IW-1:0];
      end
      if (last) busy_q <= 1'b0;
      else      cnt_q  <= cnt_q + 1'b1;
    end
  end

  a_r5_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !last |=> busy_q);
  a_r5_done_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_q);
  a_r6_cmd_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !last |=> $stable(cmd_q));
endmodule

// File: rtl/cam_hostif.sv
module cam_hostif
  import cam_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [2:0]        rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  cmd_e              cmd_i,
  input  logic              fin_found_i,
  input  logic [KEY_W-1:0]  res_ent_i,
  output logic              start_o,
  output cmd_e              cmd_o,
  output logic [KEY_W-1:0]  key_o,
  output logic [KEY_W-1:0]  mask_o,
  output logic              ins_o,
  output logic              del_o,
  output logic              irq_o
);
  logic [NWORDS-1:0][WORD_W-1:0] io_q;
  logic [KEY_W-1:0] mask_q;
  logic [NSTS-1:0]  ien_q, sts_q, sts_set, sts_clr;
  logic             ok_q, accept, chk_hit;

  assign accept  = wr_en_i & ~busy_i;
  assign start_o = accept & (wr_addr_i == A_CMD);
  assign cmd_o   = cmd_e'(wr_data_i[1:0]);
  assign ins_o   = done_i & (cmd_i == CMD_INS) & fin_found_i;
  assign del_o   = done_i & (cmd_i == CMD_DEL) & fin_found_i;
  assign chk_hit = done_i & (cmd_i == CMD_CHK) & fin_found_i;
  assign key_o   = io_q;
  assign mask_o  = mask_q;
  assign sts_set = done_i ? NSTS'(1) << cmd_i : '0;
  assign sts_clr = (wr_en_i && wr_addr_i == A_STS) ? wr_data_i[NSTS-1:0] : '0;
  assign irq_o   = |(sts_q & ien_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      io_q   <= '0;
      mask_q <= '0;
      ok_q   <= 1'b0;
      ien_q  <= '0;
      sts_q  <= '0;
    end else begin
      if (chk_hit)
        io_q <= res_ent_i;
      else if (accept && !wr_addr_i[2])
        io_q[wr_addr_i[1:0]] <= wr_data_i;
      if (done_i && cmd_i == CMD_MASK) mask_q <= io_q;
      if (done_i && cmd_i != CMD_MASK) ok_q <= fin_found_i;
      if (wr_en_i && wr_addr_i == A_IEN) ien_q <= wr_data_i[NSTS-1:0];
      sts_q <= (sts_q & ~sts_clr) | sts_set;
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      3'd0, 3'd1, 3'd2, 3'd3: rd_data_o = io_q[rd_addr_i[1:0]];
      A_FLG: rd_data_o = {{(WORD_W-2){1'b0}}, busy_i, ok_q};
      A_IEN: rd_data_o = {{(WORD_W-NSTS){1'b0}}, ien_q};
      A_STS: rd_data_o = {{(WORD_W-NSTS){1'b0}}, sts_q};
      default: rd_data_o = '0;
    endcase
  end

  a_r6_io_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !done_i |=> $stable(io_q));
  a_r3_mask_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_i && cmd_i == CMD_MASK) |=> $stable(mask_q));
  a_r4_miss_keeps_io: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && cmd_i == CMD_CHK && !fin_found_i |=> $stable(io_q) && !ok_q);
  a_r9_sts_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i && !(wr_en_i && wr_addr_i == A_STS) |=> $stable(sts_q));
endmodule

// File: rtl/cam_cmd_engine.sv
module cam_cmd_engine
  import cam_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int LATENCY = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [2:0]  wr_addr_i,
  input  logic [15:0] wr_data_i,
  input  logic [2:0]  rd_addr_i,
  output logic [15:0] rd_data_o,
  output logic        busy_o,
  output logic        irq_o
);
  localparam int IW = $clog2(DEPTH);

  logic             start, done, fin_found, cmp_hit, cmp_free, ins, del;
  cmd_e             start_cmd, run_cmd;
  logic [IW-1:0]    cmp_idx, fin_idx;
  logic [KEY_W-1:0] key, mask, res_ent;

  cam_hostif u_host (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o,
    .busy_i(busy_o), .done_i(done), .cmd_i(run_cmd), .fin_found_i(fin_found),
    .res_ent_i(res_ent), .start_o(start), .cmd_o(start_cmd), .key_o(key),
    .mask_o(mask), .ins_o(ins), .del_o(del), .irq_o
  );

  cam_seq #(.DEPTH(DEPTH), .LATENCY(LATENCY)) u_seq (
    .clk_i, .rst_ni, .start_i(start), .cmd_i(start_cmd), .cmp_hit_i(cmp_hit),
    .cmp_free_i(cmp_free), .cmp_idx_o(cmp_idx), .busy_o, .done_o(done),
    .cmd_o(run_cmd), .fin_found_o(fin_found), .fin_idx_o(fin_idx)
  );

  cam_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni, .key_i(key), .mask_i(mask), .cmp_idx_i(cmp_idx),
    .cmp_hit_o(cmp_hit), .cmp_free_o(cmp_free), .res_idx_i(fin_idx),
    .res_ent_o(res_ent), .ins_i(ins), .del_i(del)
  );
endmodule

// File: tb/sim_cam_cmd_engine.sv
module sim_cam_cmd_engine;
  localparam int DEPTH = 8;
  localparam int LAT   = 16;

  typedef struct {
    int          code;
    logic        ok;
    logic [63:0] io;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        busy, irq;

  int total = 0, bad = 0;
  bit ended = 0;
  exp_t sb[$];

  logic [63:0] m_ent [DEPTH];
  logic        m_val [DEPTH];
  logic [63:0] m_mask = '0, m_io = '0;
  logic        m_ok = 1'b0;

  always #4 clk = ~clk;

  cam_cmd_engine #(.DEPTH(DEPTH), .LATENCY(LAT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .busy_o(busy), .irq_o(irq)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic rd_key(output logic [63:0] k);
    logic [15:0] w;
    for (int i = 0; i < 4; i++) begin
      rd(3'(i), w);
      k[16*i +: 16] = w;
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_io(logic [63:0] k);
    for (int i = 0; i < 4; i++) wr(3'(i), k[16*i +: 16]);
    m_io = k;
  endtask

  function automatic int find_hit(logic [63:0] k);
    for (int i = 0; i < DEPTH; i++)
      if (m_val[i] && (((m_ent[i] ^ k) & ~m_mask) == 64'd0)) return i;
    return -1;
  endfunction

  function automatic int find_free();
    for (int i = 0; i < DEPTH; i++) if (!m_val[i]) return i;
    return -1;
  endfunction

  // driver: predict, push, issue, wait
  task automatic issue(int code, bit disturb);
    exp_t e;
    int   s;
    case (code)
      0: m_mask = m_io;
      1: begin
        s = find_free(); m_ok = (s >= 0);
        if (s >= 0) begin m_ent[s] = m_io; m_val[s] = 1'b1; end
      end
      2: begin
        s = find_hit(m_io); m_ok = (s >= 0);
        if (s >= 0) m_io = m_ent[s];
      end
      default: begin
        s = find_hit(m_io); m_ok = (s >= 0);
        if (s >= 0) m_val[s] = 1'b0;
      end
    endcase
    e.code = code; e.ok = m_ok; e.io = m_io;
    sb.push_back(e);
    wr(3'd4, 16'(code));
    if (disturb) begin
      wr(3'd0, 16'hDEAD);
      wr(3'd4, 16'd3);
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: measure busy length, compare results at completion
  initial begin
    logic        prev = 1'b0;
    int          cnt = 0;
    logic [15:0] d;
    logic [63:0] k;
    exp_t        e;
    forever begin
      @(negedge clk);
      if (busy) cnt++;
      if (prev && !busy) begin
        if (sb.size() == 0) begin
          total++; bad++;
          $display("FAIL R5 unexpected completion: actual=1 expected=0");
        end else begin
          e = sb.pop_front();
          chk("R5", 64'(cnt), 64'(LAT), "busy length");
          rd(3'd4, d);
          chk("R5", 64'(d[1]), 64'd0, "flag busy bit");
          if (e.code != 0) chk(e.code == 1 ? "R8" : e.code == 2 ? "R4" : "R7",
                               64'(d[0]), 64'(e.ok), "result flag");
          rd_key(k);
          chk(e.code == 0 ? "R3" : e.code == 2 ? "R4" : "R6", k, e.io, "key words");
          rd(3'd6, d);
          chk("R9", 64'(d[e.code]), 64'd1, "status bit");
        end
        cnt = 0;
      end
      prev = busy;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [63:0] k;
    for (int i = 0; i < DEPTH; i++) begin m_ent[i] = '0; m_val[i] = 1'b0; end
    repeat (3) @(negedge clk);
    // R10 reset state
    rd_key(k);       chk("R10", k, 64'd0, "key after reset");
    rd(3'd4, d);     chk("R10", 64'(d), 64'd0, "flags after reset");
    rd(3'd6, d);     chk("R10", 64'(d), 64'd0, "status after reset");
    chk("R10", 64'({busy, irq}), 64'd0, "busy/irq after reset");
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd5, d);     chk("R10", 64'(d), 64'd0, "enables after reset");

    wr(3'd5, 16'h0004);
    load_io(64'd0);                       issue(0, 0);   // R3 exact compare
    load_io(64'h1234_5678_9ABC_DEF0);     issue(1, 0);   // R8
    load_io(64'hFEDC_0000_1111_2222);     issue(1, 0);
    load_io(64'h1234_5678_9ABC_DEF0);     issue(2, 0);   // R4 hit
    load_io(64'hFEDC_0000_1111_2223);     issue(2, 0);   // R4 miss, one bit off
    // R1 R2: keep only word 3 in the compare
    load_io(64'h0000_FFFF_FFFF_FFFF);     issue(0, 0);
    load_io(64'h1234_AAAA_BBBB_CCCC);     issue(2, 0);
    chk("R1", m_io, 64'h1234_5678_9ABC_DEF0, "model word order");
    load_io(64'hFEDC_0101_0202_0303);     issue(2, 0);
    load_io(64'h5678_1234_1234_1234);     issue(2, 0);   // R2 low words match none, top differs
    // R9 irq and write-1-to-clear
    chk("R9", 64'(irq), 64'd1, "irq with check enabled");
    rd(3'd6, d);     chk("R9", 64'(d), 64'h7, "status bits");
    wr(3'd6, 16'h0004);
    rd(3'd6, d);     chk("R9", 64'(d), 64'h3, "status after clear");
    chk("R9", 64'(irq), 64'd0, "irq after clear");
    wr(3'd5, 16'h0002);
    chk("R9", 64'(irq), 64'd1, "irq on insert enable");
    wr(3'd6, 16'h000F);
    chk("R9", 64'(irq), 64'd0, "irq after full clear");
    // R7 delete under mask, then recheck, then delete again
    load_io(64'h1234_0000_0000_0000);     issue(3, 0);
    load_io(64'h1234_0000_0000_0000);     issue(2, 0);
    load_io(64'h1234_0000_0000_0000);     issue(3, 0);
    // R8 fill the table, then overflow
    load_io(64'd0);                       issue(0, 0);
    for (int i = 0; i < DEPTH - 1; i++) begin
      load_io(64'hA000_0000_0000_0000 + 64'(i));
      issue(1, 0);
    end
    load_io(64'hBEEF_BEEF_BEEF_BEEF);     issue(1, 0);
    chk("R8", 64'(m_ok), 64'd0, "model table full");
    load_io(64'hBEEF_BEEF_BEEF_BEEF);     issue(2, 0);
    load_io(64'hA000_0000_0000_0003);     issue(2, 0);
    // R6 writes while busy ignored
    load_io(64'h0BAD_0BAD_0BAD_0BAD);     issue(2, 1);
    repeat (3) begin
      @(negedge clk);
      chk("R6", 64'(busy), 64'd0, "no command from busy write");
    end
    chk("R6", 64'(sb.size()), 64'd0, "scoreboard drained");

    ended = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule